// File: doc/BRIEF.md
# DRAM Row Retention Profiler

This block finds out how long each DRAM row keeps its contents without refresh, and files each row into one of three refresh-interval bins. After a `start` pulse it walks through every row address in ascending order. For each row it writes a pattern of all ones, raises a hold that keeps refresh away from the memory, and then waits for a free-running millisecond tick. On every tick it reads the row once and compares the result against the pattern. The number of ticks counted when the first mismatch appears is the row's retention time.

Rows that fail from 64 ms up to 127 ms go to the fast bin, which is refreshed every 64 ms. Rows that fail from 128 ms up to 255 ms go to the middle bin, which is refreshed every 128 ms. Each of these rows is announced with a one-cycle insert strobe that carries the row address and the bin code. The strobe feeds the binning filters. A row that survives 256 ticks belongs to the default 256 ms bin and is not announced. A row that fails in under 64 ms cannot be binned safely, so it raises a sticky error flag instead. When the last row is finished, the hold drops and a completion flag stays set until the next start.

The memory side is a plain single-cycle write and a read with one-cycle latency. Ticks must be at least four clock cycles apart.

Top module: `retention_profiler`

## Requirements
- R1: Every row write drives all DATA_W data bits to 1, and each row is written exactly once per run, before any read of that row.
- R2: `refresh_hold` is high from the row write until that row is classified, covering every write and read. It is low while idle and after completion.
- R3: After the write, each `ms_tick` leads to exactly one read of the row under test, with `mem_rd` high in the cycle after the tick. No read occurs without a tick.
- R4: The retention time is the tick count at the first read whose data differs from all ones. A row whose retention is d ticks (d < 256) is read exactly d times. A row that never fails is read 255 times.
- R5: A retention of 64 to 127 ticks produces one insert with `ins_bin` = 2'b00, the fast bin.
- R6: A retention of 128 to 255 ticks produces one insert with `ins_bin` = 2'b01, the middle bin.
- R7: When the 256th tick arrives with no mismatch seen, the test ends with no read at that tick, and the row (default bin) produces no insert.
- R8: A retention under 64 ticks produces no insert and sets `err`. `err` stays set until the next `start`, which clears it.
- R9: Rows are tested in ascending order from 0 to 2^ROW_W-1. `done` rises after the last row and stays high until the next `start`. A `start` while busy is ignored.
- R10: `ins_valid` is high for exactly one cycle per inserted row, and `ins_row` carries the row's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a profiling run over all rows |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| mem_wr | output | 1 | Row write strobe |
| mem_rd | output | 1 | Row read strobe; data returns the next cycle |
| mem_addr | output | ROW_W | Row under test |
| mem_wdata | output | DATA_W | Row write pattern |
| mem_rdata | input | DATA_W | Row read data, valid one cycle after `mem_rd` |
| refresh_hold | output | 1 | Refresh suppressed while high |
| ins_valid | output | 1 | Insert strobe toward the binning filters |
| ins_row | output | ROW_W | Row address for the insert |
| ins_bin | output | 2 | Bin code: 2'b00 fast, 2'b01 middle |
| err | output | 1 | Sticky flag for a row failing under 64 ms |
| done | output | 1 | Run complete |

## Verification
A tick counter that is off by one shows up at the ports within a single row. The read count for that row changes by one, and a row whose retention sits exactly on a threshold (63/64, 127/128, 255/256) lands in the wrong bin. The insert then appears or goes missing, which the bench sees as soon as the run completes. A broken state sequence shows up in the memory traffic. Examples are a read with the hold low, a read with no tick before it, or a second write to the same row. The row model flags these in the cycle they happen. A stuck error or completion flag is exposed by a second run whose rows all stay above 64 ms.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_WAIT, ST_READ, ST_CMP, ST_CLASS
  } rp_state_e;

  localparam logic [1:0] BIN_FAST = 2'b00;
  localparam logic [1:0] BIN_MID  = 2'b01;
  localparam logic [1:0] BIN_SLOW = 2'b10;
  localparam logic [1:0] BIN_BAD  = 2'b11;

  // Maps a measured failure time (or survival) onto a bin code.
  function automatic logic [1:0] rp_bin_of(input int unsigned ms, input logic failed,
                                           input int unsigned fast_lo, input int unsigned mid_lo);
    if (!failed)           return BIN_SLOW;
    else if (ms < fast_lo) return BIN_BAD;
    else if (ms < mid_lo)  return BIN_FAST;
    else                   return BIN_MID;
  endfunction

  function automatic logic rp_is_filtered(input logic [1:0] b);
    return (b == BIN_FAST) || (b == BIN_MID);
  endfunction
endpackage

// File: rtl/rp_tick_timer.sv
module rp_tick_timer #(
  parameter int unsigned LIMIT_MS = 256,
  localparam int CNT_W = $clog2(LIMIT_MS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             limit_hit
);
  assign limit_hit = inc && (cnt == CNT_W'(LIMIT_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rp_row_check.sv
module rp_row_check #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] rdata,
  output logic              mismatch
);
  assign mismatch = valid && (rdata != {DATA_W{1'b1}});
endmodule

// File: rtl/retention_profiler.sv
module retention_profiler
  import rp_pkg::*;
#(
  parameter int unsigned ROW_W    = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FAST_LO  = 64,
  parameter int unsigned MID_LO   = 128,
  parameter int unsigned LIMIT_MS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ms_tick,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              refresh_hold,
  output logic              ins_valid,
  output logic [ROW_W-1:0]  ins_row,
  output logic [1:0]        ins_bin,
  output logic              err,
  output logic              done
);
  localparam int CNT_W = $clog2(LIMIT_MS + 1);
  localparam logic [ROW_W-1:0] LAST_ROW = {ROW_W{1'b1}};

  rp_state_e        state, state_nx;
  logic [ROW_W-1:0] row;
  logic [CNT_W-1:0] cnt;
  logic             fail_seen;

  // named internal events
  logic tick_taken, limit_hit, mismatch, row_last, bad_row;
  logic [1:0] bin_now;

  assign tick_taken = (state == ST_WAIT) && ms_tick;

  rp_tick_timer #(.LIMIT_MS(LIMIT_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_WRITE), .inc(tick_taken),
    .cnt(cnt), .limit_hit(limit_hit)
  );

  rp_row_check #(.DATA_W(DATA_W)) u_cmp (
    .valid(state == ST_CMP), .rdata(mem_rdata), .mismatch(mismatch)
  );

  assign bin_now  = rp_bin_of(int'(cnt), fail_seen, FAST_LO, MID_LO);
  assign row_last = (row == LAST_ROW);
  assign bad_row  = (state == ST_CLASS) && (bin_now == BIN_BAD);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_WRITE;
      ST_WRITE: state_nx = ST_WAIT;
      ST_WAIT:  if (limit_hit) state_nx = ST_CLASS;
                else if (tick_taken) state_nx = ST_READ;
      ST_READ:  state_nx = ST_CMP;
      ST_CMP:   state_nx = mismatch ? ST_CLASS : ST_WAIT;
      ST_CLASS: state_nx = row_last ? ST_IDLE : ST_WRITE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      row       <= '0;
      fail_seen <= 1'b0;
      err       <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && start) begin
        row  <= '0;
        err  <= 1'b0;
        done <= 1'b0;
      end
      if (state == ST_WRITE) fail_seen <= 1'b0;
      else if (mismatch)     fail_seen <= 1'b1;
      if (bad_row) err <= 1'b1;
      if (state == ST_CLASS) begin
        if (row_last) done <= 1'b1;
        else          row  <= row + 1'b1;
      end
    end
  end

  assign mem_wr       = (state == ST_WRITE);
  assign mem_rd       = (state == ST_READ);
  assign mem_addr     = row;
  assign mem_wdata    = {DATA_W{1'b1}};
  assign refresh_hold = (state != ST_IDLE);
  assign ins_valid    = (state == ST_CLASS) && rp_is_filtered(bin_now);
  assign ins_row      = row;
  assign ins_bin      = bin_now;
endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
  parameter int unsigned ROW_W    = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LIMIT_MS = 256,
  localparam int CNT_W = $clog2(LIMIT_MS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ms_tick,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              refresh_hold,
  input logic              ins_valid,
  input logic [1:0]        ins_bin,
  input logic              err,
  input logic              done,
  input logic              tick_taken,
  input logic [CNT_W-1:0]  cnt
);
  a_r1_pattern_ones: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == {DATA_W{1'b1}}));
  a_r2_hold_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> refresh_hold);
  a_r3_read_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(ms_tick));
  a_r3_tick_gives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_taken && cnt != CNT_W'(LIMIT_MS - 1)) |=> mem_rd);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(LIMIT_MS));
  a_r7_filtered_bins: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> (ins_bin == 2'b00 || ins_bin == 2'b01));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
  a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !refresh_hold);
  a_r10_one_cycle_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> !ins_valid);
endmodule

bind retention_profiler rp_checker #(.ROW_W(ROW_W), .DATA_W(DATA_W), .LIMIT_MS(LIMIT_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick), .mem_wr(mem_wr),
  .mem_rd(mem_rd), .mem_wdata(mem_wdata), .refresh_hold(refresh_hold),
  .ins_valid(ins_valid), .ins_bin(ins_bin), .err(err), .done(done),
  .tick_taken(tick_taken), .cnt(cnt)
);

// File: tb/sim_retention_profiler.sv
`timescale 1ns/1ps
module sim_retention_profiler;
  localparam int ROW_W = 4, DATA_W = 16, NROW = 1 << ROW_W, GAP = 8;

  logic clk = 0, rst_n = 0, start = 0, ms_tick = 0;
  logic mem_wr, mem_rd, refresh_hold, ins_valid, err, done;
  logic [ROW_W-1:0] mem_addr, ins_row;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [1:0] ins_bin;

  always #2 clk = ~clk;

  retention_profiler #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick), .mem_wr(mem_wr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .refresh_hold(refresh_hold), .ins_valid(ins_valid), .ins_row(ins_row),
    .ins_bin(ins_bin), .err(err), .done(done)
  );

  int checks = 0, fails = 0, model_bad = 0, order_bad = 0;
  int decay [NROW];
  int rd_cnt [NROW];
  int wr_cnt [NROW];
  int ins_cnt [NROW];
  logic [1:0] ins_got [NROW];
  int el = 0, last_wr = -1, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // free-running millisecond tick
  always @(posedge clk) begin
    cyc <= cyc + 1;
    ms_tick <= ((cyc % GAP) == GAP - 1);
  end

  // behavioural row model
  always @(posedge clk) begin
    if (mem_wr) begin
      el <= 0;
      if (mem_wdata != {DATA_W{1'b1}}) model_bad <= model_bad + 1;
      if (rd_cnt[mem_addr] != 0 || wr_cnt[mem_addr] != 0) model_bad <= model_bad + 1;
      if (int'(mem_addr) != last_wr + 1) order_bad <= order_bad + 1;
      last_wr <= int'(mem_addr);
      wr_cnt[mem_addr] <= wr_cnt[mem_addr] + 1;
    end else if (ms_tick) el <= el + 1;
    if (mem_rd) begin
      rd_cnt[mem_addr] <= rd_cnt[mem_addr] + 1;
      if (!refresh_hold) model_bad <= model_bad + 1;
      mem_rdata <= (el >= decay[mem_addr]) ? {DATA_W{1'b1}} ^ DATA_W'(1 << (el % DATA_W))
                                           : {DATA_W{1'b1}};
    end
  end

  // insert monitor
  logic prev_ins = 0;
  int dbl_ins = 0;
  always @(negedge clk) begin
    if (ins_valid) begin
      ins_cnt[ins_row] <= ins_cnt[ins_row] + 1;
      ins_got[ins_row] <= ins_bin;
      if (prev_ins) dbl_ins <= dbl_ins + 1;
    end
    prev_ins <= ins_valid;
  end

  function automatic int exp_bin(input int d);
    if (d < 64) return 3;
    if (d < 128) return 0;
    if (d < 256) return 1;
    return 2;
  endfunction

  function automatic int exp_reads(input int d);
    return (d < 256) ? d : 255;
  endfunction

  task automatic run_and_check(input string tag);
    bit exp_err = 0;
    for (int i = 0; i < NROW; i++) begin
      rd_cnt[i] = 0; wr_cnt[i] = 0; ins_cnt[i] = 0; ins_got[i] = 2'b11;
    end
    last_wr = -1; order_bad = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(refresh_hold == 1 && done == 0 && err == 0, "R9 start clears flags", done, 0);
    while (!done) begin
      @(negedge clk);
      if (done == 0 && refresh_hold == 0) begin
        chk(0, "R2 hold dropped mid run", 0, 1);
        break;
      end
    end
    for (int i = 0; i < NROW; i++) begin
      int eb = exp_bin(decay[i]);
      if (eb == 3) exp_err = 1;
      chk(wr_cnt[i] == 1, "R1 single write", wr_cnt[i], 1);
      chk(rd_cnt[i] == exp_reads(decay[i]), "R3 R4 reads per row", rd_cnt[i], exp_reads(decay[i]));
      if (eb == 0) chk(ins_cnt[i] == 1 && ins_got[i] == 2'b00, "R5 fast bin", int'(ins_got[i]), 0);
      else if (eb == 1) chk(ins_cnt[i] == 1 && ins_got[i] == 2'b01, "R6 middle bin", int'(ins_got[i]), 1);
      else if (eb == 2) chk(ins_cnt[i] == 0, "R7 default not inserted", ins_cnt[i], 0);
      else chk(ins_cnt[i] == 0, "R8 bad row not inserted", ins_cnt[i], 0);
    end
    chk(err == exp_err, {"R8 error flag ", tag}, err, exp_err);
    chk(order_bad == 0 && last_wr == NROW - 1, "R9 ascending rows", last_wr, NROW - 1);
    chk(refresh_hold == 0, "R2 hold released", refresh_hold, 0);
    repeat (20) @(negedge clk);
    chk(done == 1 && err == exp_err, "R9 R8 flags held", done, 1);
  endtask

  initial begin
    void'($urandom(32'd4211));
    for (int i = 0; i < NROW; i++) decay[i] = 1 + ($urandom % 300);
    decay[0] = 63; decay[1] = 64; decay[2] = 127; decay[3] = 128;
    decay[4] = 255; decay[5] = 256; decay[6] = 1; decay[7] = 1000;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(refresh_hold == 0 && mem_wr == 0 && mem_rd == 0, "R2 reset idle", refresh_hold, 0);
    chk(ins_valid == 0 && err == 0 && done == 0, "R10 reset outputs", ins_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(mem_wr == 0 && refresh_hold == 0, "R9 idle without start", mem_wr, 0);
    run_and_check("run1");
    // second run: start while busy must be ignored, no failing rows
    for (int i = 0; i < NROW; i++) decay[i] = 64 + ($urandom % 240);
    decay[0] = 64; decay[1] = 127; decay[2] = 128; decay[3] = 255;
    fork
      run_and_check("run2");
      begin
        repeat (500) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
      end
    join
    chk(model_bad == 0, "R1 R2 model access rules", model_bad, 0);
    chk(dbl_ins == 0, "R10 insert width", dbl_ins, 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule